// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind a serial-bus front end in a small non-volatile byte memory. The front end loads a starting word address, then hands over each received data byte with a one-cycle strobe. The block stores these bytes in an eight-slot page buffer. The buffer slot is chosen by the low address bits, and those bits wrap inside the page. When the bus stop pulse arrives, the block runs a programming cycle. The cycle is a timed erase phase followed by eight timed byte-program slots. Each slot that received data is written into a 256-byte array. The array is modelled as registers, and a combinational read port gives access to it.

If the burst is longer than one page, or the front end raises its overflow flag, the whole transaction is dropped and nothing is programmed. The block holds `busy` high from the cycle after the stop pulse until the sequence has finished. While `busy` is high it ignores every bus-side input.

The sequencer has five states:
- IDLE: waits for an address load, which moves it to COLLECT.
- COLLECT: accepts bytes. A stop pulse moves it to ERASE when at least one byte is held and no overflow is flagged. Otherwise the stop pulse sends it back to IDLE and the buffer is cleared.
- ERASE: lasts `T_ERASE` cycles and then moves to PROGRAM.
- PROGRAM: steps through the eight slots, spending `T_PROG` cycles on each. After the last slot it moves to DONE.
- DONE: lasts one cycle, clears the slot valid bits and returns to IDLE.

Top module: `pwb_page_prog`

## Requirements
- R1: After reset `busy` is low, the buffer is empty, the state is IDLE, and every array byte reads 8'hFF.
- R2: An address load in IDLE or COLLECT takes page = `addr_in[7:3]`. The first data byte goes to slot `addr_in[2:0]`, that is, array address {page, slot}.
- R3: After each stored byte, only the three low address bits increment, modulo 8. The page bits stay fixed, so a burst starting at slot 6 writes slots 6, 7, 0, 1 and so on.
- R4: A ninth data byte before the stop pulse marks the transaction overflowed. The stop pulse then starts no cycle, `busy` stays low and the array is unchanged.
- R5: `ovf_in` high during COLLECT has the same discarding effect as R4.
- R6: A stop pulse in COLLECT with no stored byte starts no cycle.
- R7: After a valid stop pulse, `busy` rises in the next cycle. It stays high for exactly T_ERASE + 8*T_PROG + 1 cycles.
- R8: No array write occurs during the first T_ERASE busy cycles. The byte of program slot i is written at the end of busy cycle T_ERASE + (i+1)*T_PROG.
- R9: While `busy` is high, `addr_ld`, `byte_stb`, `stop_pls` and `ovf_in` have no effect.
- R10: Only slots that received data in the current transaction are written. Valid bits clear when the cycle ends, so stale bytes are never written again.
- R11: An address load during COLLECT restarts the transaction and drops the bytes already stored.
- R12: `rd_data` shows the array byte at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Load the start word address (one-cycle pulse) |
| addr_in | input | 8 | Start word address |
| byte_stb | input | 1 | Data byte strobe |
| byte_in | input | 8 | Data byte |
| stop_pls | input | 1 | Bus stop condition pulse |
| ovf_in | input | 1 | Front-end overflow flag |
| rd_addr | input | 8 | Array read address |
| busy | output | 1 | High for the whole erase/program cycle |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_data | output | 8 | Array read data |

## Verification
The bound checker looks at every cycle. It checks that `busy` rises only after a stop pulse, and that each busy period has exactly the required length. It checks that no write happens inside the erase window, that the page bits of the write address stay stable through a cycle, and that overflowed or empty transactions never start a cycle. The bench scenarios are needed for the rest, because those results only show up in array contents compared against a reference model. These cover page wrap, slot placement, discarding of overlong bursts, restart on a new address, stale valid bits, and inputs that arrive during a busy cycle and must be ignored.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_ERASE,
        ST_PROGRAM,
        ST_DONE
    } pwb_state_t;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int SLOTS = 8,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld,
    input  logic [$clog2(SLOTS)-1:0]    ld_idx,
    input  logic                        clr,
    input  logic                        push,
    input  logic [DW-1:0]               din,
    input  logic [$clog2(SLOTS)-1:0]    rd_idx,
    output logic [DW-1:0]               rd_data,
    output logic                        rd_valid,
    output logic [$clog2(SLOTS+1)-1:0]  fill,
    output logic                        full
);
    localparam int IW = $clog2(SLOTS);
    localparam int CW = $clog2(SLOTS+1);

    logic [DW-1:0]    data_q [SLOTS];
    logic [SLOTS-1:0] valid_q;
    logic [IW-1:0]    ptr_q;

    assign full     = (fill == CW'(SLOTS));
    assign rd_data  = data_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
            fill    <= '0;
            for (int i = 0; i < SLOTS; i++) data_q[i] <= '0;
        end else if (ld || clr) begin
            valid_q <= '0;
            fill    <= '0;
            ptr_q   <= ld ? ld_idx : '0;
        end else if (push && !full) begin
            data_q[ptr_q]  <= din;
            valid_q[ptr_q] <= 1'b1;
            ptr_q          <= ptr_q + IW'(1);
            fill           <= fill + CW'(1);
        end
    end
endmodule

// File: rtl/pwb_phase_timer.sv
module pwb_phase_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    assign done = run && (cnt_q == limit - TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run||done) cnt_q <= '0;
        else                 cnt_q <= cnt_q + TW'(1);
    end
endmodule

// File: rtl/pwb_cell_array.sv
module pwb_cell_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    assign rdata = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/pwb_page_prog.sv
module pwb_page_prog
    import pwb_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int PAGE    = 8,
    parameter int T_ERASE = 350000,
    parameter int T_PROG  = 350000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_ld,
    input  logic [AW-1:0] addr_in,
    input  logic          byte_stb,
    input  logic [DW-1:0] byte_in,
    input  logic          stop_pls,
    input  logic          ovf_in,
    input  logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic [DW-1:0] rd_data
);
    localparam int IW   = $clog2(PAGE);
    localparam int HW   = AW - IW;
    localparam int CW   = $clog2(PAGE + 1);
    localparam int TMAX = (T_ERASE > T_PROG) ? T_ERASE : T_PROG;
    localparam int TW   = $clog2(TMAX + 1);

    pwb_state_t    state, nstate;
    logic [HW-1:0] page_q;
    logic [IW-1:0] slot_q;
    logic          ovf_q;

    logic          open_win, ld_go, push_go, stop_col, discard, start;
    logic          t_run, t_done, last_slot;
    logic [TW-1:0] t_limit;
    logic [CW-1:0] buf_fill;
    logic          buf_full, buf_valid;
    logic [DW-1:0] buf_data;

    // Bus-side qualifiers: everything is gated off outside IDLE/COLLECT
    assign open_win  = (state == ST_IDLE) || (state == ST_COLLECT);
    assign ld_go     = addr_ld && open_win;
    assign push_go   = byte_stb && (state == ST_COLLECT);
    assign stop_col  = stop_pls && (state == ST_COLLECT);
    assign discard   = stop_col && (ovf_q || (buf_fill == '0));
    assign start     = stop_col && !discard;
    assign t_run     = (state == ST_ERASE) || (state == ST_PROGRAM);
    assign t_limit   = (state == ST_ERASE) ? TW'(T_ERASE) : TW'(T_PROG);
    assign last_slot = (slot_q == IW'(PAGE - 1));

    pwb_page_buf #(.SLOTS(PAGE), .DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ld_go),
        .ld_idx   (addr_in[IW-1:0]),
        .clr      (discard || (state == ST_DONE)),
        .push     (push_go),
        .din      (byte_in),
        .rd_idx   (slot_q),
        .rd_data  (buf_data),
        .rd_valid (buf_valid),
        .fill     (buf_fill),
        .full     (buf_full)
    );

    pwb_phase_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .limit (t_limit),
        .done  (t_done)
    );

    pwb_cell_array #(.AW(AW), .DW(DW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Next-state decision
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (ld_go) nstate = ST_COLLECT;
            ST_COLLECT: if (stop_col) nstate = start ? ST_ERASE : ST_IDLE;
            ST_ERASE:   if (t_done) nstate = ST_PROGRAM;
            ST_PROGRAM: if (t_done && last_slot) nstate = ST_DONE;
            ST_DONE:    nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Transaction context: page, overflow mark, program slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            ovf_q  <= 1'b0;
            slot_q <= '0;
        end else begin
            if (ld_go) page_q <= addr_in[AW-1:IW];

            if (ld_go || state == ST_IDLE)
                ovf_q <= 1'b0;
            else if (state == ST_COLLECT && (ovf_in || (push_go && buf_full)))
                ovf_q <= 1'b1;

            if (state == ST_ERASE)
                slot_q <= '0;
            else if (state == ST_PROGRAM && t_done)
                slot_q <= slot_q + IW'(1);
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        arr_we    = 1'b0;
        arr_addr  = {page_q, slot_q};
        arr_wdata = buf_data;
        unique case (state)
            ST_IDLE, ST_COLLECT: busy = 1'b0;
            ST_ERASE, ST_DONE:   busy = 1'b1;
            ST_PROGRAM: begin
                busy   = 1'b1;
                arr_we = t_done && buf_valid;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int AW      = 8,
    parameter int CW      = 4,
    parameter int T_ERASE = 4,
    parameter int T_PROG  = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_pls,
    input logic          busy,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr,
    input pwb_state_t    state,
    input logic [CW-1:0] fill,
    input logic          ovf_flag
);
    localparam int TOTAL = T_ERASE + 8 * T_PROG + 1;

    int bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pls));

    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == TOTAL));

    a_r8_no_write_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (busy && bcnt >= T_ERASE));

    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[AW-1:3]));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && ovf_flag && stop_pls) |=> !busy);

    a_r6_no_empty_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && fill == '0 && stop_pls) |=> !busy);
endmodule

bind pwb_page_prog pwb_checker #(
    .AW(AW), .CW(CW), .T_ERASE(T_ERASE), .T_PROG(T_PROG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_pls (stop_pls),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .state    (state),
    .fill     (buf_fill),
    .ovf_flag (ovf_q)
);

// File: tb/sim_pwb_page_prog.sv
module sim_pwb_page_prog;
    localparam int TE  = 12;
    localparam int TP  = 10;
    localparam int TOT = TE + 8 * TP + 1;

    // vector: {addr[7:0], nbytes[3:0], seed[7:0]}
    localparam logic [19:0] VEC [7] = '{
        {8'h00, 4'd8, 8'h10},   // R2 full page
        {8'h18, 4'd1, 8'hC0},   // R10 stale slots must not be rewritten
        {8'h2E, 4'd5, 8'h20},   // R3 wrap 6,7,0,1,2
        {8'h40, 4'd9, 8'h30},   // R4 overlong burst
        {8'h50, 4'd0, 8'h00},   // R6 address-only
        {8'hF7, 4'd3, 8'hE0},   // R3 wrap in top page
        {8'h0A, 4'd4, 8'h90}    // R2 mid-page start
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_ld = 1'b0, byte_stb = 1'b0, stop_pls = 1'b0, ovf_in = 1'b0;
    logic [7:0] addr_in = '0, byte_in = '0, rd_addr = '0;
    logic       busy, arr_we;
    logic [7:0] arr_addr, arr_wdata, rd_data;

    logic [7:0] model [256];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwb_page_prog #(.T_ERASE(TE), .T_PROG(TP)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .stop_pls(stop_pls),
        .ovf_in(ovf_in), .rd_addr(rd_addr), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_tx(input logic [7:0] a, input int n, input logic [7:0] s, input bit stp);
        @(negedge clk); addr_in = a; addr_ld = 1'b1;
        @(negedge clk); addr_ld = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_in = s + 8'(i); byte_stb = 1'b1;
            @(negedge clk); byte_stb = 1'b0;
        end
        if (stp) begin
            stop_pls = 1'b1;
            @(negedge clk); stop_pls = 1'b0;
        end
    endtask

    task automatic model_apply(input logic [7:0] a, input int n, input logic [7:0] s);
        if (n > 0 && n <= 8)
            for (int i = 0; i < n; i++)
                model[{a[7:3], 3'(int'(a[2:0]) + i)}] = s + 8'(i);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic cmp_all(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #0.1;
            if (rd_data !== model[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (bad != 0) begin
            rd_addr = 8'(first);
            #0.1;
            chk(1'b0, req, int'(rd_data), int'(model[first]));
        end else begin
            chk(1'b1, req, 0, 0);
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        rd_addr = 8'h00; #0.1;
        chk(rd_data == 8'hFF, "R1 array erased after reset", rd_data, 8'hFF);
        rd_addr = 8'hFF; #0.1;
        chk(rd_data == 8'hFF, "R1 array erased after reset (top)", rd_data, 8'hFF);

        // Table walk: R2 R3 R4 R6 R10 R12
        for (int v = 0; v < 7; v++) begin
            logic [7:0] a;
            int n;
            logic [7:0] s;
            bit exp_busy;
            a = VEC[v][19:12];
            n = int'(VEC[v][11:8]);
            s = VEC[v][7:0];
            exp_busy = (n > 0 && n <= 8);
            send_tx(a, n, s, 1'b1);
            chk(busy == exp_busy, "R7/R4/R6 busy after stop", busy, exp_busy);
            wait_idle();
            model_apply(a, n, s);
            cmp_all("R2/R3/R4/R6/R10/R12 array contents");
        end

        // R7 busy duration
        send_tx(8'h60, 2, 8'hA0, 1'b1);
        cnt = 0;
        while (busy && cnt < 10000) begin cnt++; @(negedge clk); end
        chk(cnt == TOT, "R7 busy duration", cnt, TOT);
        model_apply(8'h60, 2, 8'hA0);

        // R8 write timing of slot 0
        rd_addr = 8'h70;
        send_tx(8'h70, 1, 8'h33, 1'b1);
        repeat (TE + TP - 1) @(negedge clk);
        chk(rd_data == 8'hFF, "R8 not yet written before slot end", rd_data, 8'hFF);
        @(negedge clk);
        chk(rd_data == 8'h33, "R8 written at slot end", rd_data, 8'h33);
        wait_idle();
        model_apply(8'h70, 1, 8'h33);

        // R9 inputs ignored while busy
        send_tx(8'h88, 2, 8'h01, 1'b1);
        ovf_in = 1'b1;
        send_tx(8'h90, 1, 8'h77, 1'b1);
        ovf_in = 1'b0;
        chk(busy == 1'b1, "R9 still busy", busy, 1);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R9 stop during busy started no cycle", busy, 0);
        model_apply(8'h88, 2, 8'h01);
        cmp_all("R9 array contents");

        // R5 external overflow discards
        send_tx(8'hA0, 3, 8'h44, 1'b0);
        ovf_in = 1'b1; @(negedge clk); ovf_in = 1'b0;
        stop_pls = 1'b1; @(negedge clk); stop_pls = 1'b0;
        chk(busy == 1'b0, "R5 no cycle after ovf_in", busy, 0);
        cmp_all("R5 array unchanged");

        // R11 address load in COLLECT restarts
        send_tx(8'hB0, 2, 8'h50, 1'b0);
        send_tx(8'hC3, 1, 8'h66, 1'b1);
        chk(busy == 1'b1, "R11 cycle after restart", busy, 1);
        wait_idle();
        model_apply(8'hC3, 1, 8'h66);
        cmp_all("R11 only restarted data programmed");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule